// File: doc/BRIEF.md
# I2C Master Bus Timing Engine

This block turns a handful of programmable interval counts into the actual SCL and SDA drive waveforms of an I2C master. A sequencer above it issues one of three requests (open a transfer with a START, clock out one bit, or close with a STOP). The engine answers each request with the correctly timed pin activity and a one-cycle completion pulse. It does not sequence bytes, handle acknowledge bits or buffer data; that belongs to the sequencer.

All intervals count prescaled ticks. One tick lasts `DIV+1` input clocks, and a programmed count of N lasts N+1 ticks. The prescaler restarts at the start of every phase, so each interval is an exact multiple of the tick. The engine watches SCL on the bus through a two-stage synchronizer and a glitch filter of programmable depth. It waits for the filtered level before it times the high and low halves of the clock. A slave that holds SCL low therefore lengthens the bit. With no stretching, one bit period is `(DIV+1)*(L+H+2) + 8 + 2*FLT` input clocks.

Outputs are active-high pull-down enables: a 1 on `scl_low_o` or `sda_low_o` means the engine pulls that line low, and a 0 means it releases the line.

Top module: `i2c_tgen`

## Requirements
- R1: While reset is held, and in the idle phase, both drive outputs are 0 (lines released). After reset, `ready_o` is 1 and `done_o` is 0.
- R2: A START accepted in idle pulls SDA low (DIV+1)*(START_SU+1) clocks after acceptance. It pulls SCL low a further (DIV+1)*(START_HD+1) clocks later. `done_o` and `ready_o` rise 3+FLT clocks after SCL is pulled low.
- R3: For a bit request, SDA takes its new value (`sda_low_o` = 1 for a 0 bit, 0 for a 1 bit) exactly (DIV+1)*(HOLD+1) clocks after acceptance. SCL is released (DIV+1)*max(L+1, HOLD+SETUP+2) clocks after acceptance.
- R4: With SCL unstretched, SCL is pulled low again 4+FLT+(DIV+1)*(H+1) clocks after it was released.
- R5: With `req_bit` held high and L+1 >= HOLD+SETUP+2, consecutive SCL falling edges are (DIV+1)*(L+H+2)+8+2*FLT clocks apart, and the low part lasts 4+FLT+(DIV+1)*(L+1) clocks.
- R6: The high-period count starts only once filtered SCL is high. When a slave holds SCL low, SCL is pulled low 4+FLT+(DIV+1)*(H+1) clocks after the clock edge before which the bus level went high.
- R7: A STOP request pulls SDA low (DIV+1)*(HOLD+1) clocks after acceptance. It releases SCL at the low-phase length of R3. It releases SDA 4+FLT+(DIV+1)*(STOP_SU+1) clocks after SCL release.
- R8: After the STOP releases SDA, a bus-free window of (DIV+1)*(FREE+1) clocks passes before `ready_o` returns. `done_o` pulses for one cycle at the end of that window.
- R9: A high pulse on `scl_in` shorter than FLT+1 clocks, arriving while SCL is stretched, does not start the high-period count.
- R10: Requests are honoured only while `ready_o` is 1. START is honoured only in idle, and bit and STOP only after a completed phase. STOP takes priority over bit. Any other request leaves both lines unchanged.
- R11: SDA changes while SCL is released only at the START and STOP edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Prescaler value, tick = cfg_div+1 clocks |
| cfg_start_su | input | CNT_W | START setup count |
| cfg_start_hd | input | CNT_W | START hold count |
| cfg_stop_su | input | CNT_W | STOP setup count |
| cfg_dat_su | input | CNT_W | Data setup count before SCL rises |
| cfg_dat_hd | input | CNT_W | Data hold count after SCL falls |
| cfg_scl_lo | input | CNT_W | SCL low count |
| cfg_scl_hi | input | CNT_W | SCL high count |
| cfg_free | input | CNT_W | Bus-free count after STOP |
| cfg_flt | input | FLT_W | SCL glitch filter depth |
| req_start | input | 1 | Request a START |
| req_bit | input | 1 | Request one data bit |
| bit_val | input | 1 | Value of the requested bit |
| req_stop | input | 1 | Request a STOP |
| scl_in | input | 1 | Sampled SCL bus level |
| scl_low_o | output | 1 | Pull SCL low |
| sda_low_o | output | 1 | Pull SDA low |
| ready_o | output | 1 | A request is accepted this cycle |
| done_o | output | 1 | One-cycle phase completion pulse |

## Verification
A corrupted tick count or prescaler shows up as a pin edge off by a whole multiple of DIV+1 clocks, and is seen at the first SDA change or SCL release after the request. A wrong phase state surfaces as SDA moving while SCL is released, or as `ready_o` and `done_o` arriving early or never. A filter or stretch fault moves the next SCL fall by whole clocks within one high period. Each edge is timed against a bench cycle counter.

// File: rtl/i2c_tgen_pkg.sv
package i2c_tgen_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_ST_SU, PH_ST_HD, PH_FALL, PH_HELD,
    PH_LOW, PH_HI_WAIT, PH_HI, PH_SP_SU, PH_FREE
  } phase_e;

  // Number of ticks in the SCL low phase: at least the programmed low time,
  // and long enough to fit data hold plus data setup.
  function automatic logic [15:0] low_span(input logic [15:0] lo,
                                           input logic [15:0] hold,
                                           input logic [15:0] setup);
    logic [15:0] by_lo, by_data;
    by_lo   = lo + 16'd1;
    by_data = hold + setup + 16'd2;
    return (by_lo > by_data) ? by_lo : by_data;
  endfunction

  // True on the final tick of an interval whose last tick index is 'last'.
  function automatic logic at_last(input logic tick,
                                   input logic [15:0] done_ticks,
                                   input logic [15:0] last);
    return tick && (done_ticks == last);
  endfunction

endpackage

// File: rtl/i2c_tgen_presc.sv
module i2c_tgen_presc #(
  parameter int DIV_W = 8,
  parameter int TW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick,
  output logic [TW-1:0]    ticks
);
  logic [DIV_W-1:0] pre_q;

  assign tick = (pre_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ticks <= '0;
    end else if (restart) begin
      pre_q <= '0;
      ticks <= '0;
    end else if (tick) begin
      pre_q <= '0;
      ticks <= ticks + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_tgen_filt.sv
module i2c_tgen_filt #(
  parameter int FLT_W = 3,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLT_W-1:0] depth,
  input  logic             raw,
  output logic             filt
);
  logic [SYNC-1:0]  sync_q;
  logic [FLT_W-1:0] run_q;
  logic             synced;

  generate
    for (genvar g = 0; g < SYNC; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b1;
        else        sync_q[g] <= (g == 0) ? raw : sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign synced = sync_q[SYNC-1];

  // The new level is taken once it has been seen depth+1 samples in a row.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt  <= 1'b1;
      run_q <= '0;
    end else if (synced != filt) begin
      if (run_q == depth) begin
        filt  <= synced;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end
endmodule

// File: rtl/i2c_tgen.sv
module i2c_tgen
  import i2c_tgen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 8,
  parameter int FLT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [CNT_W-1:0] cfg_start_su,
  input  logic [CNT_W-1:0] cfg_start_hd,
  input  logic [CNT_W-1:0] cfg_stop_su,
  input  logic [CNT_W-1:0] cfg_dat_su,
  input  logic [CNT_W-1:0] cfg_dat_hd,
  input  logic [CNT_W-1:0] cfg_scl_lo,
  input  logic [CNT_W-1:0] cfg_scl_hi,
  input  logic [CNT_W-1:0] cfg_free,
  input  logic [FLT_W-1:0] cfg_flt,
  input  logic             req_start,
  input  logic             req_bit,
  input  logic             bit_val,
  input  logic             req_stop,
  input  logic             scl_in,
  output logic             scl_low_o,
  output logic             sda_low_o,
  output logic             ready_o,
  output logic             done_o
);
  localparam int TW = CNT_W + 2;

  phase_e        state, state_n;
  logic          tick;
  logic [TW-1:0] ticks;
  logic          scl_f;
  logic          stop_q, bit_q;
  logic          op_go, restart;
  logic          end_st_su, end_st_hd, end_lo, end_hi, end_sp_su, end_free;
  logic          sda_upd;
  logic [15:0]   lo_last;

  i2c_tgen_presc #(.DIV_W(DIV_W), .TW(TW)) u_presc (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .restart(restart),
    .tick(tick), .ticks(ticks)
  );

  i2c_tgen_filt #(.FLT_W(FLT_W), .SYNC(2)) u_filt (
    .clk(clk), .rst_n(rst_n), .depth(cfg_flt), .raw(scl_in), .filt(scl_f)
  );

  assign lo_last   = low_span(16'(cfg_scl_lo), 16'(cfg_dat_hd), 16'(cfg_dat_su)) - 16'd1;
  assign end_st_su = at_last(tick, 16'(ticks), 16'(cfg_start_su));
  assign end_st_hd = at_last(tick, 16'(ticks), 16'(cfg_start_hd));
  assign end_lo    = at_last(tick, 16'(ticks), lo_last);
  assign end_hi    = at_last(tick, 16'(ticks), 16'(cfg_scl_hi));
  assign end_sp_su = at_last(tick, 16'(ticks), 16'(cfg_stop_su));
  assign end_free  = at_last(tick, 16'(ticks), 16'(cfg_free));
  assign sda_upd   = at_last(tick, 16'(ticks), 16'(cfg_dat_hd));

  assign ready_o = (state == PH_IDLE) || (state == PH_HELD) ||
                   (state == PH_FALL && !scl_f);
  assign done_o  = (state == PH_FALL && !scl_f) ||
                   (state == PH_FREE && end_free);
  assign op_go   = ready_o && (state != PH_IDLE) && (req_stop || req_bit);
  assign restart = (state_n != state);

  always_comb begin
    state_n = state;
    unique case (state)
      PH_IDLE:    if (req_start) state_n = PH_ST_SU;
      PH_ST_SU:   if (end_st_su) state_n = PH_ST_HD;
      PH_ST_HD:   if (end_st_hd) state_n = PH_FALL;
      PH_FALL:    if (!scl_f)    state_n = op_go ? PH_LOW : PH_HELD;
      PH_HELD:    if (op_go)     state_n = PH_LOW;
      PH_LOW:     if (end_lo)    state_n = PH_HI_WAIT;
      PH_HI_WAIT: if (scl_f)     state_n = stop_q ? PH_SP_SU : PH_HI;
      PH_HI:      if (end_hi)    state_n = PH_FALL;
      PH_SP_SU:   if (end_sp_su) state_n = PH_FREE;
      PH_FREE:    if (end_free)  state_n = PH_IDLE;
      default:                   state_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PH_IDLE;
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
      stop_q    <= 1'b0;
      bit_q     <= 1'b0;
    end else begin
      state     <= state_n;
      scl_low_o <= (state_n == PH_FALL) || (state_n == PH_HELD) ||
                   (state_n == PH_LOW);
      if (op_go) begin
        stop_q <= req_stop;
        bit_q  <= bit_val;
      end
      if (state == PH_ST_SU && state_n == PH_ST_HD)
        sda_low_o <= 1'b1;
      else if (state == PH_SP_SU && state_n == PH_FREE)
        sda_low_o <= 1'b0;
      else if (state == PH_LOW && sda_upd)
        sda_low_o <= stop_q | ~bit_q;
    end
  end
endmodule

// File: rtl/i2c_tgen_chk.sv
module i2c_tgen_chk
  import i2c_tgen_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input phase_e state,
  input logic   scl_low,
  input logic   sda_low,
  input logic   ready,
  input logic   done,
  input logic   tick,
  input logic   scl_f
);
  // R11: with SCL released, SDA only moves at the START and STOP edges
  assert_sda_only_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_low != $past(sda_low)) && !scl_low && !$past(scl_low))
      |-> ($past(state) == PH_ST_SU || $past(state) == PH_SP_SU));

  assert_hi_after_filtered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_HI && $past(state) == PH_HI_WAIT) |-> $past(scl_f));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_free_to_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_FREE && done) |=> (ready && !scl_low && !sda_low));

  assert_sda_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_LOW && $past(state) == PH_LOW && sda_low != $past(sda_low))
      |-> $past(tick));

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_IDLE) |-> (!scl_low && !sda_low && ready));
endmodule

bind i2c_tgen i2c_tgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .scl_low(scl_low_o),
  .sda_low(sda_low_o), .ready(ready_o), .done(done_o), .tick(tick),
  .scl_f(scl_f)
);

// File: tb/i2c_tgen_bench.sv
`timescale 1ns/1ps
module i2c_tgen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] div = 8'd1, st_su = 8'd3, st_hd = 8'd2, sp_su = 8'd2;
  logic [7:0] d_su = 8'd1, d_hd = 8'd1, lo = 8'd3, hi = 8'd2, fr = 8'd4;
  logic [2:0] flt = 3'd0;
  logic req_start = 1'b0, req_bit = 1'b0, bit_val = 1'b0, req_stop = 1'b0;
  logic stretch = 1'b0;
  logic scl_low, sda_low, ready, done, scl_in;
  int cyc = 0;
  int checks = 0;
  int failures = 0;

  assign scl_in = ~scl_low & ~stretch;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_tgen u_i2c_tgen (
    .clk(clk), .rst_n(rst_n), .cfg_div(div), .cfg_start_su(st_su),
    .cfg_start_hd(st_hd), .cfg_stop_su(sp_su), .cfg_dat_su(d_su),
    .cfg_dat_hd(d_hd), .cfg_scl_lo(lo), .cfg_scl_hi(hi), .cfg_free(fr),
    .cfg_flt(flt), .req_start(req_start), .req_bit(req_bit),
    .bit_val(bit_val), .req_stop(req_stop), .scl_in(scl_in),
    .scl_low_o(scl_low), .sda_low_o(sda_low), .ready_o(ready), .done_o(done)
  );

  // {div, lo, hi, hold, setup, filter, bit}
  localparam logic [55:0] VEC [5] = '{
    56'h00_05_04_01_01_00_01,
    56'h01_03_02_00_00_02_00,
    56'h02_04_06_03_02_07_01,
    56'h03_02_01_00_01_01_00,
    56'h00_09_09_02_03_04_01
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int low_exp(input int l, input int h, input int s);
    if (l + 1 >= h + s + 2) return l + 1;
    return h + s + 2;
  endfunction

  task automatic wait_scl(input logic v, output int t);
    do @(negedge clk); while (scl_low !== v);
    t = cyc;
  endtask

  task automatic wait_sda(input logic v, output int t);
    do @(negedge clk); while (sda_low !== v);
    t = cyc;
  endtask

  task automatic wait_ready(output int t);
    do @(negedge clk); while (ready !== 1'b1);
    t = cyc;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    int t0, t1, t2, t3, t4, bad;
    repeat (4) @(negedge clk);
    check("R1 reset scl", int'(scl_low), 0);
    check("R1 reset sda", int'(sda_low), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(ready), 1);
    check("R1 done after reset", int'(done), 0);

    // R10: bit request in idle is ignored
    req_bit = 1'b1; bit_val = 1'b0;
    @(negedge clk); req_bit = 1'b0;
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (scl_low || sda_low) bad++;
    end
    check("R10 bit in idle ignored", bad, 0);

    // R2: START
    req_start = 1'b1;
    @(negedge clk); req_start = 1'b0; t0 = cyc;
    wait_sda(1'b1, t1);
    check("R2 start setup", t1 - t0, 2 * 4);
    wait_scl(1'b1, t2);
    check("R2 start hold", t2 - t1, 2 * 3);
    wait_ready(t3);
    check("R2 ready after fall", t3 - t2, 3);
    check("R2 done pulse", int'(done), 1);

    // R10: START while holding the bus is ignored
    @(negedge clk);
    req_start = 1'b1;
    @(negedge clk); req_start = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!scl_low || !sda_low) bad++;
    end
    check("R10 start while held ignored", bad, 0);

    // R3/R4/R11: table of bit timings
    for (int i = 0; i < 5; i++) begin
      int d, l, h, hd, su, f, b;
      d = VEC[i][55:48]; l = VEC[i][47:40]; h = VEC[i][39:32];
      hd = VEC[i][31:24]; su = VEC[i][23:16]; f = VEC[i][15:8]; b = VEC[i][7:0];
      div = 8'(d); lo = 8'(l); hi = 8'(h); d_hd = 8'(hd); d_su = 8'(su);
      flt = 3'(f);
      bit_val = b[0]; req_bit = 1'b1;
      @(negedge clk); req_bit = 1'b0; t0 = cyc;
      wait_sda(~b[0], t1);
      check("R3 data hold", t1 - t0, (d + 1) * (hd + 1));
      wait_scl(1'b0, t2);
      check("R3 low phase", t2 - t0, (d + 1) * low_exp(l, hd, su));
      check("R11 sda inside low", int'(t1 > t0 && t1 < t2), 1);
      wait_scl(1'b1, t3);
      check("R4 high phase", t3 - t2, 4 + f + (d + 1) * (h + 1));
      wait_ready(t4);
    end

    // R5: back-to-back bits
    div = 8'd1; lo = 8'd4; hi = 8'd3; d_hd = 8'd1; d_su = 8'd1; flt = 3'd2;
    bit_val = 1'b1; req_bit = 1'b1;
    wait_scl(1'b0, t0);
    wait_scl(1'b1, t1);
    wait_scl(1'b0, t2);
    wait_scl(1'b1, t3);
    req_bit = 1'b0;
    check("R5 low time", t2 - t1, 4 + 2 + 2 * 5);
    check("R5 bit period", t3 - t1, 2 * 9 + 8 + 2 * 2);
    wait_ready(t4);

    // R6: slave stretches SCL
    div = 8'd0; lo = 8'd2; hi = 8'd5; d_hd = 8'd0; d_su = 8'd0; flt = 3'd1;
    stretch = 1'b1; bit_val = 1'b1; req_bit = 1'b1;
    @(negedge clk); req_bit = 1'b0;
    wait_scl(1'b0, t0);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (scl_low) bad++;
    end
    check("R6 waits while stretched", bad, 0);
    stretch = 1'b0; t1 = cyc;
    wait_scl(1'b1, t2);
    check("R6 high after stretch", t2 - t1, 4 + 1 + 6);
    wait_ready(t4);

    // R9: short glitch during stretch is filtered
    hi = 8'd2; flt = 3'd3;
    stretch = 1'b1; req_bit = 1'b1;
    @(negedge clk); req_bit = 1'b0;
    wait_scl(1'b0, t0);
    repeat (5) @(negedge clk);
    stretch = 1'b0;
    repeat (2) @(negedge clk);
    stretch = 1'b1;
    repeat (10) @(negedge clk);
    check("R9 glitch ignored", int'(scl_low), 0);
    stretch = 1'b0; t1 = cyc;
    wait_scl(1'b1, t2);
    check("R9 high after glitch", t2 - t1, 4 + 3 + 3);
    wait_ready(t4);

    // R7/R8: STOP and bus-free window
    div = 8'd1; lo = 8'd3; hi = 8'd2; d_hd = 8'd1; d_su = 8'd1; flt = 3'd0;
    sp_su = 8'd2; fr = 8'd4;
    req_stop = 1'b1;
    @(negedge clk); req_stop = 1'b0; t0 = cyc;
    wait_sda(1'b1, t1);
    check("R7 stop sda low", t1 - t0, 2 * 2);
    wait_scl(1'b0, t2);
    check("R7 stop scl release", t2 - t0, 2 * 4);
    wait_sda(1'b0, t3);
    check("R7 stop setup", t3 - t2, 4 + 2 * 3);
    @(negedge clk); req_start = 1'b1;
    @(negedge clk); req_start = 1'b0;
    bad = 0; t4 = 0;
    for (int i = 0; i < 200 && t4 == 0; i++) begin
      @(negedge clk);
      if (scl_low || sda_low) bad++;
      if (ready) t4 = cyc;
    end
    check("R8 bus free window", t4 - t3, 2 * 5);
    check("R10 start during free ignored", bad, 0);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (scl_low || sda_low || !ready) bad++;
    end
    check("R1 idle after stop", bad, 0);

    report();
    $finish;
  end
endmodule